// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Data Gearbox

The gearbox sits between a memory core that moves one 2n-bit word per clock and an external data bus that moves one n-bit beat on each clock edge. On the write side, the controller's strobe is valid for a clock, and the block takes the beat latched on the strobe's rising edge, the beat latched on its falling edge, and one mask bit per byte for each beat. It joins the two beats into a single core word and sends the word with a byte-enable vector. It also counts words so that it can flag the last word of each burst.

On the read side, a single start pulse opens a burst. The block first spends one clock of preamble, with the pins driven and the strobe held low. It then asks the core for one word per clock and splits each word into a rising-edge beat and a falling-edge beat. During each data clock the strobe is high in the first half and low in the second, so its edges line up with the data edges. After the last beat it keeps the strobe low and driven for half a clock of postamble, then releases the pins. The burst length is 2, 4 or 8 beats, which is 1, 2 or 4 core words. It is chosen by a two-bit select that is sampled when a burst starts.

The pin side is modelled at clock granularity. Each pin signal comes as a pair, one value for the rising-edge half of the clock and one for the falling-edge half. The output-enable is also split into two halves, so the postamble can end in the middle of a clock.

Top module: `ddr_gearbox`

## Requirements
- R1: While rstN is low at a rising clock edge, every output afterwards reads zero: both output-enable halves, both strobe halves, both data beats, coreRdReq, coreWrValid and coreWrLast.
- R2: If dqsInActive is high at an edge, then after that edge coreWrValid is 1 and coreWrData holds {dqInFall, dqInRise}, with the rising-edge beat in the low half. If dqsInActive is low, coreWrValid is 0 after the edge.
- R3: coreWrBe bit i (i < BYTES) is the inverse of dmInRise bit i. Bit BYTES+i is the inverse of dmInFall bit i. A masked lane (mask bit 1) clears its enable and an unmasked lane sets it.
- R4: coreWrLast is 1 together with coreWrValid on the final word of each write burst and 0 on every other cycle. The word count restarts after the final word.
- R5: Burst length select encoding: 0 means 2 beats (1 word), 1 means 4 beats (2 words), and 2 or 3 means 8 beats (4 words). For a write the select is sampled on the first captured word of a burst. For a read it is sampled together with an accepted rdStart. Later changes do not affect a burst already in progress.
- R6: When rdStart is accepted, the next clock is a preamble: oeRise=1, oeFall=1, dqsOutRise=0, dqsOutFall=0, and both data beats are 0.
- R7: During each read data clock, oeRise=oeFall=1, dqsOutRise=1, dqsOutFall=0, dqOutRise is the low half of the core word and dqOutFall is the high half.
- R8: coreRdReq is 1 in the preamble clock and in every data clock except the last. The word on coreRdData at the rising edge that ends a clock with coreRdReq=1 is the word that appears on the pins during the next clock.
- R9: The clock after the last data clock is a postamble with oeRise=1, oeFall=0 and both strobe halves 0. The clock after that is idle.
- R10: rdStart is ignored from preamble through postamble: the burst in progress keeps its length and timing, and no new preamble follows.
- R11: When neither a read window nor a postamble is active, both output-enable halves, both strobe halves and both data beats are 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| blSel | input | 2 | Burst length select |
| rdStart | input | 1 | Start a read burst |
| coreRdData | input | 2*BEAT_W | Core word to be sent |
| coreRdReq | output | 1 | Core word consumed at the next edge |
| dqOutRise | output | BEAT_W | Read beat for the rising-edge half |
| dqOutFall | output | BEAT_W | Read beat for the falling-edge half |
| dqsOutRise | output | 1 | Read strobe level in the first half |
| dqsOutFall | output | 1 | Read strobe level in the second half |
| oeRise | output | 1 | Pin drive enable in the first half |
| oeFall | output | 1 | Pin drive enable in the second half |
| dqsInActive | input | 1 | Write strobe pulsed during this clock |
| dqInRise | input | BEAT_W | Beat captured on the write strobe rising edge |
| dqInFall | input | BEAT_W | Beat captured on the write strobe falling edge |
| dmInRise | input | BEAT_W/8 | Byte masks for the rising-edge beat |
| dmInFall | input | BEAT_W/8 | Byte masks for the falling-edge beat |
| coreWrData | output | 2*BEAT_W | Assembled write word |
| coreWrBe | output | BEAT_W/4 | Byte enables for the write word |
| coreWrValid | output | 1 | Write word valid |
| coreWrLast | output | 1 | Final word of the write burst |

## Verification
A new rdStart can arrive in the same clock that the block is in its postamble. Holding rdStart high across a whole one-word read provokes this. The bench expects the request to be dropped during the postamble and accepted again one clock later, in the idle clock. A write capture can also fall in the same clock as any read phase, and a write burst can end in the very clock a read starts. Random strobe and start traffic mixes the two paths. A cycle model in the bench then requires each path to behave exactly as it would on its own.

// File: rtl/gb_pkg.sv
package gb_pkg;
  localparam int MAX_WORDS = 4;
  localparam int CNT_W = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_DATA, PH_POST} rdPhase_t;

  typedef struct packed {
    logic loadRd;
    logic drvData;
    logic wrCapture;
    logic wrLast;
  } gbStrobe_t;

  function automatic logic [CNT_W-1:0] lastIdxFor(input logic [1:0] sel);
    case (sel)
      2'd0: lastIdxFor = CNT_W'(0);
      2'd1: lastIdxFor = CNT_W'(1);
      default: lastIdxFor = CNT_W'(MAX_WORDS - 1);
    endcase
  endfunction
endpackage

// File: rtl/gb_ctrl.sv
module gb_ctrl
  import gb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  blSel,
  input  logic        rdStart,
  input  logic        dqsInActive,
  output gbStrobe_t   stb,
  output logic        coreRdReq,
  output logic        dqsOutRise,
  output logic        dqsOutFall,
  output logic        oeRise,
  output logic        oeFall
);
  rdPhase_t phase;
  logic [CNT_W-1:0] rdCnt, rdLastIdx;
  logic [CNT_W-1:0] wrCnt, wrLastIdx, wrIdxNow;
  logic rdAtEnd;

  assign rdAtEnd = (rdCnt == rdLastIdx);
  assign wrIdxNow = (wrCnt == '0) ? lastIdxFor(blSel) : wrLastIdx;

  always_comb begin
    stb.loadRd    = (phase == PH_PRE) || ((phase == PH_DATA) && !rdAtEnd);
    stb.drvData   = (phase == PH_DATA);
    stb.wrCapture = dqsInActive;
    stb.wrLast    = (wrCnt == wrIdxNow);
  end

  assign coreRdReq  = stb.loadRd;
  assign oeRise     = (phase != PH_IDLE);
  assign oeFall     = (phase == PH_PRE) || (phase == PH_DATA);
  assign dqsOutRise = (phase == PH_DATA);
  assign dqsOutFall = 1'b0;

  // read sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      rdCnt     <= '0;
      rdLastIdx <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (rdStart) begin
          phase     <= PH_PRE;
          rdLastIdx <= lastIdxFor(blSel);
        end
        PH_PRE: begin
          phase <= PH_DATA;
          rdCnt <= '0;
        end
        PH_DATA: begin
          if (rdAtEnd) phase <= PH_POST;
          else         rdCnt <= rdCnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // write word counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt     <= '0;
      wrLastIdx <= '0;
    end else if (dqsInActive) begin
      wrLastIdx <= wrIdxNow;
      wrCnt     <= stb.wrLast ? '0 : wrCnt + 1'b1;
    end
  end

  p_pre_to_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_PRE |=> phase == PH_DATA);
  p_post_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_POST |=> phase == PH_IDLE);
  p_req_in_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    coreRdReq |-> (phase == PH_PRE || phase == PH_DATA));
  p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && rdStart) |=> phase != PH_PRE);
  p_len_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |=> $stable(rdLastIdx));
endmodule

// File: rtl/gb_datapath.sv
module gb_datapath
  import gb_pkg::*;
#(
  parameter int BEAT_W = 16,
  localparam int BYTES = BEAT_W / 8,
  localparam int WORD_W = 2 * BEAT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  gbStrobe_t           stb,
  input  logic [WORD_W-1:0]   coreRdData,
  output logic [BEAT_W-1:0]   dqOutRise,
  output logic [BEAT_W-1:0]   dqOutFall,
  input  logic [BEAT_W-1:0]   dqInRise,
  input  logic [BEAT_W-1:0]   dqInFall,
  input  logic [BYTES-1:0]    dmInRise,
  input  logic [BYTES-1:0]    dmInFall,
  output logic [WORD_W-1:0]   coreWrData,
  output logic [2*BYTES-1:0]  coreWrBe,
  output logic                coreWrValid,
  output logic                coreWrLast
);
  logic [WORD_W-1:0] rdHold;
  logic [2*BYTES-1:0] beNext;

  always_ff @(posedge clk) begin
    if (!rstN) rdHold <= '0;
    else if (stb.loadRd) rdHold <= coreRdData;
  end

  assign dqOutRise = stb.drvData ? rdHold[BEAT_W-1:0]      : '0;
  assign dqOutFall = stb.drvData ? rdHold[WORD_W-1:BEAT_W] : '0;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign beNext[b]         = ~dmInRise[b];
    assign beNext[BYTES + b] = ~dmInFall[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreWrData  <= '0;
      coreWrBe    <= '0;
      coreWrValid <= 1'b0;
      coreWrLast  <= 1'b0;
    end else begin
      coreWrValid <= stb.wrCapture;
      coreWrLast  <= stb.wrCapture && stb.wrLast;
      if (stb.wrCapture) begin
        coreWrData <= {dqInFall, dqInRise};
        coreWrBe   <= beNext;
      end
    end
  end

  p_valid_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCapture |=> coreWrValid);
  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCapture |=> !coreWrValid);
  p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreWrLast |-> coreWrValid);
  p_quiet_pins_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.drvData |-> (dqOutRise == '0 && dqOutFall == '0));
endmodule

// File: rtl/ddr_gearbox.sv
module ddr_gearbox
  import gb_pkg::*;
#(
  parameter int BEAT_W = 16,
  localparam int BYTES = BEAT_W / 8,
  localparam int WORD_W = 2 * BEAT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          blSel,
  input  logic                rdStart,
  input  logic [WORD_W-1:0]   coreRdData,
  output logic                coreRdReq,
  output logic [BEAT_W-1:0]   dqOutRise,
  output logic [BEAT_W-1:0]   dqOutFall,
  output logic                dqsOutRise,
  output logic                dqsOutFall,
  output logic                oeRise,
  output logic                oeFall,
  input  logic                dqsInActive,
  input  logic [BEAT_W-1:0]   dqInRise,
  input  logic [BEAT_W-1:0]   dqInFall,
  input  logic [BYTES-1:0]    dmInRise,
  input  logic [BYTES-1:0]    dmInFall,
  output logic [WORD_W-1:0]   coreWrData,
  output logic [2*BYTES-1:0]  coreWrBe,
  output logic                coreWrValid,
  output logic                coreWrLast
);
  gbStrobe_t stb;

  gb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .blSel(blSel), .rdStart(rdStart),
    .dqsInActive(dqsInActive), .stb(stb), .coreRdReq(coreRdReq),
    .dqsOutRise(dqsOutRise), .dqsOutFall(dqsOutFall),
    .oeRise(oeRise), .oeFall(oeFall)
  );

  gb_datapath #(.BEAT_W(BEAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .coreRdData(coreRdData),
    .dqOutRise(dqOutRise), .dqOutFall(dqOutFall),
    .dqInRise(dqInRise), .dqInFall(dqInFall),
    .dmInRise(dmInRise), .dmInFall(dmInFall),
    .coreWrData(coreWrData), .coreWrBe(coreWrBe),
    .coreWrValid(coreWrValid), .coreWrLast(coreWrLast)
  );

  p_strobe_inside_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqsOutRise |-> (oeRise && oeFall));
  p_fall_drive_needs_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    oeFall |-> oeRise);
endmodule

// File: tb/ddr_gearbox_tb_top.sv
`timescale 1ns/1ps
module ddr_gearbox_tb_top;
  localparam int BW = 16;
  localparam int NB = BW / 8;
  localparam int WW = 2 * BW;

  logic clk = 0;
  logic rstN = 0;
  logic [1:0] blSel = 0;
  logic rdStart = 0;
  logic [WW-1:0] coreRdData = 0;
  logic coreRdReq;
  logic [BW-1:0] dqOutRise, dqOutFall;
  logic dqsOutRise, dqsOutFall, oeRise, oeFall;
  logic dqsInActive = 0;
  logic [BW-1:0] dqInRise = 0, dqInFall = 0;
  logic [NB-1:0] dmInRise = 0, dmInFall = 0;
  logic [WW-1:0] coreWrData;
  logic [2*NB-1:0] coreWrBe;
  logic coreWrValid, coreWrLast;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddr_gearbox #(.BEAT_W(BW)) dut_i (.*);

  // behavioural reference model
  int mPh = 0;          // 0 idle, 1 preamble, 2 data, 3 postamble
  int mLeft = 0;        // words still to fetch
  logic [WW-1:0] mWord = 0;
  int mWcnt = 0, mWtot = 1;
  bit eValid = 0, eLast = 0;
  logic [WW-1:0] eWrData = 0;
  logic [2*NB-1:0] eBe = 0;

  function automatic int wordsOf(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mLeft = 0; mWord = 0; mWcnt = 0;
      eValid = 0; eLast = 0; eWrData = 0; eBe = 0;
    end else begin
      case (mPh)
        0: if (rdStart) begin mPh = 1; mLeft = wordsOf(blSel); end
        1: begin mWord = coreRdData; mLeft--; mPh = 2; end
        2: if (mLeft == 0) mPh = 3; else begin mWord = coreRdData; mLeft--; end
        default: mPh = 0;
      endcase
      eValid = dqsInActive;
      eLast = 0;
      if (dqsInActive) begin
        if (mWcnt == 0) mWtot = wordsOf(blSel);
        mWcnt++;
        if (mWcnt == mWtot) begin eLast = 1; mWcnt = 0; end
        eWrData = {dqInFall, dqInRise};
        for (int b = 0; b < NB; b++) begin
          eBe[b] = ~dmInRise[b];
          eBe[NB + b] = ~dmInFall[b];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit eReq;
    eReq = (mPh == 1) || (mPh == 2 && mLeft != 0);
    chk("R8 coreRdReq", coreRdReq, eReq);
    case (mPh)
      1: begin
        chk("R6 oe", {oeRise, oeFall}, 2'b11);
        chk("R6 dqs", {dqsOutRise, dqsOutFall}, 2'b00);
        chk("R6 dq", {dqOutRise, dqOutFall}, 0);
      end
      2: begin
        chk("R7 oe", {oeRise, oeFall}, 2'b11);
        chk("R7 dqs", {dqsOutRise, dqsOutFall}, 2'b10);
        chk("R7 dqRise low half", dqOutRise, mWord[BW-1:0]);
        chk("R7 dqFall high half", dqOutFall, mWord[WW-1:BW]);
      end
      3: begin
        chk("R9 oe", {oeRise, oeFall}, 2'b10);
        chk("R9 dqs", {dqsOutRise, dqsOutFall}, 2'b00);
      end
      default: begin
        chk("R11 oe", {oeRise, oeFall}, 2'b00);
        chk("R11 dqs", {dqsOutRise, dqsOutFall}, 2'b00);
        chk("R11 dq", {dqOutRise, dqOutFall}, 0);
      end
    endcase
    chk("R2 coreWrValid", coreWrValid, eValid);
    chk("R4 coreWrLast", coreWrLast, eLast);
    if (eValid) begin
      chk("R2 coreWrData", coreWrData, eWrData);
      chk("R3 coreWrBe", coreWrBe, eBe);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {oeRise, oeFall}, 0);
    chk("R1 dqs", {dqsOutRise, dqsOutFall}, 0);
    chk("R1 dq", {dqOutRise, dqOutFall}, 0);
    chk("R1 req", coreRdReq, 0);
    chk("R1 wr", {coreWrValid, coreWrLast}, 0);
    rstN = 1;
    // R10 / R5: hold rdStart through short reads, start hits postamble
    blSel = 0; rdStart = 1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk); compareAll();
      coreRdData = {$urandom, $urandom};
    end
    rdStart = 0;
    // R5: every select, read and write bursts with mid-burst select changes
    for (int s = 0; s < 4; s++) begin
      blSel = 2'(s);
      rdStart = 1;
      dqsInActive = 1;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk); compareAll();
        rdStart = (c == 3);
        blSel = (c >= 1) ? 2'($urandom) : 2'(s);
        coreRdData = {$urandom, $urandom};
        dqInRise = BW'($urandom); dqInFall = BW'($urandom);
        dmInRise = NB'($urandom); dmInFall = NB'($urandom);
      end
      dqsInActive = 0; rdStart = 0;
      repeat (8) begin @(negedge clk); compareAll(); end
    end
    // random mixed traffic: reads and writes in the same cycles
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk); compareAll();
      rdStart = ($urandom % 4) == 0;
      dqsInActive = ($urandom % 2) == 0;
      if (($urandom % 8) == 0) blSel = 2'($urandom);
      coreRdData = {$urandom, $urandom};
      dqInRise = BW'($urandom); dqInFall = BW'($urandom);
      dmInRise = NB'($urandom); dmInFall = NB'($urandom);
    end
    rdStart = 0; dqsInActive = 0;
    repeat (10) begin @(negedge clk); compareAll(); end
    finishRun();
  end
endmodule